// File: doc/BRIEF.md
# Integer ALU with Carry and Condition Field

This unit performs one 32-bit integer operation per accepted strobe. An operation select picks among additions, subtractions, compares, divides, shifts, negate and leading-zero count. The operands are two 32-bit registers, a 16-bit immediate, an incoming carry and a sticky overflow flag. Each accepted operation yields a result word, an outgoing carry and a 4-bit condition field. All three are registered on the clock edge that accepts the strobe.

The carry, compare and divide rules are architectural rules, not generic flag logic. Add-carrying compares the wrapped sum against the first operand. Subtract-carrying compares the difference against the minuend. Divide corner cases return fixed values instead of trapping. For every operation the condition field carries the sticky overflow flag in its lowest bit. For compares the rest of the field holds the comparison outcome; for every other operation it holds the sign of the result.

Top module: `int_alu_core`

## Requirements
- R1: While reset is low, every output is zero. `out_valid` rises exactly one cycle after an accepted `in_valid`. In a cycle without `in_valid`, `result`, `carry_out` and `cond_out` keep their previous values.
- R2: Code 0 (add) returns A+B and passes `carry_in` through unchanged to `carry_out`. Code 1 (add-carrying) returns A+B and sets `carry_out` exactly when the wrapped sum is unsigned-less than A.
- R3: Code 2 (subtract-from) returns B−A. Code 3 (subtract-from carrying) returns B−A and sets `carry_out` exactly when the unsigned result is less than or equal to B.
- R4: Code 4 (add-to-zero extended) returns A+`carry_in` and sets `carry_out` only when this wraps. Code 5 (add-to-minus-one extended) returns A+`carry_in`−1 and sets `carry_out` when A is nonzero or `carry_in` is 1.
- R5: The compares are code 6 (signed, A vs B), code 7 (signed, A vs the sign-extended immediate), code 8 (unsigned, A vs B) and code 9 (unsigned, A vs the zero-extended immediate). Each returns a zero result and passes `carry_in` through. The condition field bits [3:1] are 100 for less, 010 for greater and 001 for equal.
- R6: For every non-compare operation, `cond_out[3:1]` encodes the signed result against zero (100 negative, 010 positive, 001 zero). For every operation, `cond_out[0]` equals `sticky_ov`.
- R7: Code 10 (signed divide) truncates toward zero. A zero divisor, or 0x80000000 divided by 0xFFFFFFFF, returns the dividend's sign bit copied into all 32 bits.
- R8: Code 11 (unsigned divide) returns A/B, and returns zero when B is zero.
- R9: Code 12 (shift left) and code 13 (shift right logical) take the amount from B[5:0] and ignore B[31:6]. When B[5] is set, the result is zero.
- R10: Code 14 (algebraic shift right by immediate) shifts A right by imm[4:0] and fills with the sign bit. It sets `carry_out` only when A is negative and at least one 1 bit is shifted out.
- R11: Code 15 (negate) returns −A, except that 0x80000000 is returned unchanged.
- R12: Code 16 (count leading zeros) returns the number of zero bits above the most significant 1 in A, and returns 32 for A = 0. Codes 12, 13, 15, 16 and the divides pass `carry_in` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 5 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| imm | input | 16 | Immediate operand |
| carry_in | input | 1 | Incoming carry |
| sticky_ov | input | 1 | Sticky overflow flag, copied into condition bit 0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered result |
| carry_out | output | 1 | Registered carry |
| cond_out | output | 4 | Registered condition field |

## Verification
The hardest cases to reach are the carry boundaries, where a generic carry formula and the architectural one differ by a single input. These include subtract-carrying with equal operands, add-to-minus-one with a zero operand and a set carry, and the algebraic shift whose shifted-out bits are all zero against one with a single 1 bit lost. The stimulus places vectors exactly on each of these edges. It also drives the two signed-divide corners and the shift amount with only bit 5 set, or with bits above bit 5 set. Idle cycles with changed operands in between show that the registered outputs hold.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_SUBF  = 5'd2,
    OP_SUBFC = 5'd3,
    OP_ADDZE = 5'd4,
    OP_ADDME = 5'd5,
    OP_CMPS  = 5'd6,
    OP_CMPSI = 5'd7,
    OP_CMPU  = 5'd8,
    OP_CMPUI = 5'd9,
    OP_DIVS  = 5'd10,
    OP_DIVU  = 5'd11,
    OP_SHL   = 5'd12,
    OP_SHR   = 5'd13,
    OP_SRAI  = 5'd14,
    OP_NEG   = 5'd15,
    OP_CLZ   = 5'd16
  } alu_op_e;

  localparam logic [2:0] REL_LT = 3'b100;
  localparam logic [2:0] REL_GT = 3'b010;
  localparam logic [2:0] REL_EQ = 3'b001;
endpackage

// File: rtl/int_alu_arith.sv
`timescale 1ns/1ps
module int_alu_arith
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [IW-1:0]  imm,
  input  logic           ci,
  output logic [W-1:0]   res,
  output logic           co,
  output logic [2:0]     rel,
  output logic           is_cmp
);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum_ab, diff_ba, ze_sum, rhs;
  logic         lt_s, gt_s, lt_u, gt_u;

  always_comb begin
    sum_ab  = a + b;
    diff_ba = b - a;
    ze_sum  = a + W'(ci);
    if (op == OP_CMPSI)      rhs = {{(W-IW){imm[IW-1]}}, imm};
    else if (op == OP_CMPUI) rhs = {{(W-IW){1'b0}}, imm};
    else                     rhs = b;
    lt_s = $signed(a) < $signed(rhs);
    gt_s = $signed(a) > $signed(rhs);
    lt_u = a < rhs;
    gt_u = a > rhs;
  end

  always_comb begin
    res    = '0;
    co     = ci;
    rel    = REL_EQ;
    is_cmp = 1'b0;
    case (op)
      OP_ADD:   res = sum_ab;
      OP_ADDC:  begin res = sum_ab;  co = (sum_ab < a);    end
      OP_SUBF:  res = diff_ba;
      OP_SUBFC: begin res = diff_ba; co = (diff_ba <= b);  end
      OP_ADDZE: begin res = ze_sum;  co = (ze_sum < a);    end
      OP_ADDME: begin res = ze_sum + {W{1'b1}}; co = (a != '0) | ci; end
      OP_CMPS, OP_CMPSI: begin
        is_cmp = 1'b1;
        rel = lt_s ? REL_LT : (gt_s ? REL_GT : REL_EQ);
      end
      OP_CMPU, OP_CMPUI: begin
        is_cmp = 1'b1;
        rel = lt_u ? REL_LT : (gt_u ? REL_GT : REL_EQ);
      end
      OP_NEG:   res = (a == MIN_VAL) ? a : (~a + 1'b1);
      default:  res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_shift.sv
`timescale 1ns/1ps
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W) + 1
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [SHW-1:0]  amt,
  input  logic [SHW-2:0]  sh_imm,
  input  logic            ci,
  output logic [W-1:0]    res,
  output logic            co
);
  localparam int CW = $clog2(W) + 1;

  logic [W-1:0]  lost_mask;
  logic [CW-1:0] zcnt;
  logic          seen_one;

  always_comb begin
    zcnt     = CW'(W);
    seen_one = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!seen_one && a[i]) begin
        zcnt     = CW'(W - 1 - i);
        seen_one = 1'b1;
      end
    end
  end

  always_comb begin
    lost_mask = ~({W{1'b1}} << sh_imm);
    res = '0;
    co  = ci;
    case (op)
      OP_SHL:  res = amt[SHW-1] ? '0 : (a << amt[SHW-2:0]);
      OP_SHR:  res = amt[SHW-1] ? '0 : (a >> amt[SHW-2:0]);
      OP_SRAI: begin
        res = W'($signed(a) >>> sh_imm);
        co  = a[W-1] && ((a & lost_mask) != '0);
      end
      OP_CLZ:  res = {{(W-CW){1'b0}}, zcnt};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_div.sv
`timescale 1ns/1ps
module int_alu_div #(
  parameter int W = 32
) (
  input  logic          signed_mode,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  res
);
  localparam logic [W-1:0] MIN_VAL = {1'b1, {(W-1){1'b0}}};

  logic sdiv_corner;

  always_comb begin
    sdiv_corner = (b == '0) || ((a == MIN_VAL) && (b == {W{1'b1}}));
    if (signed_mode) begin
      if (sdiv_corner) res = {W{a[W-1]}};
      else             res = W'($signed(a) / $signed(b));
    end else begin
      if (b == '0)     res = '0;
      else             res = a / b;
    end
  end
endmodule

// File: rtl/int_alu_core.sv
`timescale 1ns/1ps
module int_alu_core
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_sel,
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b,
  input  logic [IW-1:0]   imm,
  input  logic            carry_in,
  input  logic            sticky_ov,
  output logic            out_valid,
  output logic [W-1:0]    result,
  output logic            carry_out,
  output logic [3:0]      cond_out
);
  localparam int SHW = $clog2(W) + 1;

  alu_op_e      op;
  logic [W-1:0] ar_res, sh_res, dv_res, res_nxt;
  logic         ar_co, sh_co, co_nxt, ar_cmp;
  logic [2:0]   ar_rel, rel_nxt;
  logic [3:0]   cond_nxt;

  assign op = alu_op_e'(op_sel);

  int_alu_arith #(.W(W), .IW(IW)) u_arith (
    .op(op), .a(opnd_a), .b(opnd_b), .imm(imm), .ci(carry_in),
    .res(ar_res), .co(ar_co), .rel(ar_rel), .is_cmp(ar_cmp)
  );

  int_alu_shift #(.W(W), .SHW(SHW)) u_shift (
    .op(op), .a(opnd_a), .amt(opnd_b[SHW-1:0]), .sh_imm(imm[SHW-2:0]),
    .ci(carry_in), .res(sh_res), .co(sh_co)
  );

  int_alu_div #(.W(W)) u_div (
    .signed_mode(op == OP_DIVS), .a(opnd_a), .b(opnd_b), .res(dv_res)
  );

  // next-state selection
  always_comb begin
    case (op)
      OP_DIVS, OP_DIVU: begin res_nxt = dv_res; co_nxt = carry_in; end
      OP_SHL, OP_SHR, OP_SRAI, OP_CLZ: begin res_nxt = sh_res; co_nxt = sh_co; end
      default: begin res_nxt = ar_res; co_nxt = ar_co; end
    endcase
    if (ar_cmp)                rel_nxt = ar_rel;
    else if (res_nxt[W-1])     rel_nxt = REL_LT;
    else if (res_nxt != '0)    rel_nxt = REL_GT;
    else                       rel_nxt = REL_EQ;
    cond_nxt = {rel_nxt, sticky_ov};
  end

  // output registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      cond_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= res_nxt;
        carry_out <= co_nxt;
        cond_out  <= cond_nxt;
      end
    end
  end

  assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(carry_out) && $stable(cond_out)));
  assert_cond_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(cond_out[3:1]) == 1));
  assert_ov_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (cond_out[0] == $past(sticky_ov)));
  assert_udiv_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_DIVU && opnd_b == '0) |=> (result == '0));
  assert_shift_big_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_sel == OP_SHL || op_sel == OP_SHR) && opnd_b[SHW-1]) |=> (result == '0));
  assert_neg_min_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_NEG && opnd_a == {1'b1, {(W-1){1'b0}}}) |=> (result == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: tb/test_int_alu_core.sv
`timescale 1ns/1ps
module test_int_alu_core;
  typedef struct {
    logic [31:0] res;
    logic        ca;
    logic [3:0]  cond;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op_sel;
  logic [31:0] opnd_a, opnd_b;
  logic [15:0] imm;
  logic        carry_in, sticky_ov;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out;
  logic [3:0]  cond_out;

  exp_t        sb_q[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  int          cycles = 0;
  bit          done   = 0;
  logic [31:0] last_res;
  logic [3:0]  last_cond;

  always #10 clk = ~clk;

  int_alu_core i_int_alu_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .carry_in(carry_in),
    .sticky_ov(sticky_ov), .out_valid(out_valid), .result(result),
    .carry_out(carry_out), .cond_out(cond_out)
  );

  // reference model written from the requirements
  function automatic exp_t model(input logic [4:0] op, input logic [31:0] a, b,
                                 input logic [15:0] im, input logic ci, ov);
    exp_t e;
    logic [32:0] wide;
    logic [63:0] t;
    logic [31:0] rhs;
    logic        cmp, lt, gt;
    longint      sa, sb;
    int          k;
    e.res = 0; e.ca = ci; cmp = 0; lt = 0; gt = 0;
    case (op)
      5'd0:  e.res = a + b;
      5'd1:  begin wide = {1'b0, a} + {1'b0, b}; e.res = wide[31:0]; e.ca = wide[32]; end
      5'd2:  e.res = b - a;
      5'd3:  begin wide = {1'b0, b} + {1'b0, ~a} + 33'd1; e.res = wide[31:0]; e.ca = wide[32]; end
      5'd4:  begin wide = {1'b0, a} + 33'(ci); e.res = wide[31:0]; e.ca = wide[32]; end
      5'd5:  begin wide = {1'b0, a} + 33'(ci) + 33'h0FFFFFFFF; e.res = wide[31:0]; e.ca = wide[32]; end
      5'd6, 5'd7: begin
        cmp = 1; rhs = (op == 5'd7) ? {{16{im[15]}}, im} : b;
        sa = longint'($signed(a)); sb = longint'($signed(rhs));
        lt = sa < sb; gt = sa > sb;
      end
      5'd8, 5'd9: begin
        cmp = 1; rhs = (op == 5'd9) ? {16'h0, im} : b;
        lt = a < rhs; gt = a > rhs;
      end
      5'd10: begin
        if (b == 0 || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) e.res = {32{a[31]}};
        else begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          e.res = 32'(sa / sb);
        end
      end
      5'd11: e.res = (b == 0) ? 32'h0 : a / b;
      5'd12: e.res = b[5] ? 32'h0 : 32'({32'h0, a} << b[4:0]);
      5'd13: e.res = b[5] ? 32'h0 : 32'({32'h0, a} >> b[4:0]);
      5'd14: begin
        t = {a, 32'h0} >> im[4:0];
        e.res = 32'($signed(a) >>> im[4:0]);
        e.ca  = a[31] && (t[31:0] != 0);
      end
      5'd15: e.res = (a == 32'h8000_0000) ? a : 32'h0 - a;
      5'd16: begin
        k = 0;
        while (k < 32 && a[31-k] == 1'b0) k++;
        e.res = 32'(k);
      end
      default: e.res = 0;
    endcase
    if (cmp)            e.cond = {lt, gt, !lt && !gt, ov};
    else if (e.res[31]) e.cond = {3'b100, ov};
    else if (e.res != 0) e.cond = {3'b010, ov};
    else                e.cond = {3'b001, ov};
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [31:0] a, b,
                       input logic [15:0] im, input logic ci, ov, input string tag);
    exp_t e;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; imm = im; carry_in = ci; sticky_ov = ov;
    in_valid = 1'b1;
    e = model(op, a, b, im, ci, ov);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      n_chk++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1: result strobe with empty scoreboard, result=%h expected none", result);
      end else begin
        e = sb_q.pop_front();
        if (result !== e.res || carry_out !== e.ca || cond_out !== e.cond) begin
          n_fail++;
          $display("FAIL %s: res=%h ca=%b cond=%b expected res=%h ca=%b cond=%b",
                   e.tag, result, carry_out, cond_out, e.res, e.ca, e.cond);
        end
      end
      last_res  = result;
      last_cond = cond_out;
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      done = 1;
      report();
    end
  end

  task automatic idle_hold_check(input string tag);
    @(negedge clk);
    in_valid = 1'b0; op_sel = 5'd0; opnd_a = 32'h1234_5678; opnd_b = 32'h1111_1111;
    sticky_ov = ~sticky_ov;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== last_res || cond_out !== last_cond) begin
      n_fail++;
      $display("FAIL %s: idle valid=%b res=%h cond=%b expected valid=0 res=%h cond=%b",
               tag, out_valid, result, cond_out, last_res, last_cond);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 0; opnd_a = 0; opnd_b = 0;
    imm = 0; carry_in = 0; sticky_ov = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== 32'h0 || carry_out !== 1'b0 || cond_out !== 4'h0) begin
      n_fail++;
      $display("FAIL R1: reset valid=%b res=%h ca=%b cond=%b expected all zero",
               out_valid, result, carry_out, cond_out);
    end
    rst_n = 1'b1;

    // R2
    drive(5'd0, 32'd5, 32'd7, 16'h0, 1'b1, 1'b0, "R2 add passes carry");
    drive(5'd1, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0, "R2 addc wrap");
    drive(5'd1, 32'd1, 32'd2, 16'h0, 1'b1, 1'b0, "R2 addc no wrap clears");
    // R3
    drive(5'd2, 32'd3, 32'd10, 16'h0, 1'b0, 1'b0, "R3 subf");
    drive(5'd3, 32'd5, 32'd5, 16'h0, 1'b0, 1'b0, "R3 subfc equal");
    drive(5'd3, 32'd6, 32'd5, 16'h0, 1'b1, 1'b0, "R3 subfc borrow");
    drive(5'd3, 32'd0, 32'd0, 16'h0, 1'b0, 1'b0, "R3 subfc zero");
    // R4
    drive(5'd4, 32'hFFFF_FFFF, 32'd0, 16'h0, 1'b1, 1'b0, "R4 addze wrap");
    drive(5'd4, 32'd5, 32'd0, 16'h0, 1'b1, 1'b0, "R4 addze plain");
    drive(5'd5, 32'd0, 32'd0, 16'h0, 1'b0, 1'b0, "R4 addme zero no carry");
    drive(5'd5, 32'd0, 32'd0, 16'h0, 1'b1, 1'b0, "R4 addme zero carry");
    drive(5'd5, 32'd3, 32'd0, 16'h0, 1'b0, 1'b0, "R4 addme nonzero");
    idle_hold_check("R1 hold after addme");
    // R5
    drive(5'd6, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b1, 1'b0, "R5 signed less");
    drive(5'd8, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0, "R5 unsigned greater");
    drive(5'd6, 32'd42, 32'd42, 16'h0, 1'b0, 1'b0, "R5 signed equal");
    drive(5'd7, 32'hFFFF_FFFE, 32'd0, 16'hFFFE, 1'b0, 1'b0, "R5 signed imm equal");
    drive(5'd9, 32'h0000_FFFE, 32'd0, 16'hFFFE, 1'b0, 1'b0, "R5 unsigned imm equal");
    drive(5'd9, 32'd5, 32'd0, 16'h8000, 1'b0, 1'b0, "R5 unsigned imm less");
    drive(5'd7, 32'd5, 32'd0, 16'h8000, 1'b0, 1'b1, "R5 signed imm greater ov");
    // R6
    drive(5'd0, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b1, "R6 negative with ov");
    drive(5'd2, 32'd9, 32'd9, 16'h0, 1'b0, 1'b1, "R6 zero with ov");
    drive(5'd0, 32'd1, 32'd1, 16'h0, 1'b0, 1'b0, "R6 positive");
    // R7
    drive(5'd10, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0, "R7 min over minus one");
    drive(5'd10, 32'd7, 32'd0, 16'h0, 1'b0, 1'b0, "R7 positive over zero");
    drive(5'd10, 32'hFFFF_FFF9, 32'd0, 16'h0, 1'b0, 1'b0, "R7 negative over zero");
    drive(5'd10, 32'hFFFF_FFF9, 32'd2, 16'h0, 1'b0, 1'b0, "R7 truncation");
    drive(5'd10, 32'd100, 32'hFFFF_FFF9, 16'h0, 1'b0, 1'b0, "R7 negative divisor");
    // R8
    drive(5'd11, 32'd7, 32'd0, 16'h0, 1'b1, 1'b0, "R8 divu by zero");
    drive(5'd11, 32'hFFFF_FFFF, 32'd16, 16'h0, 1'b0, 1'b0, "R8 divu normal");
    // R9
    drive(5'd12, 32'h0000_0003, 32'd31, 16'h0, 1'b0, 1'b0, "R9 shl 31");
    drive(5'd12, 32'hFFFF_FFFF, 32'd32, 16'h0, 1'b0, 1'b0, "R9 shl 32 zero");
    drive(5'd13, 32'hFFFF_FFFF, 32'h3F, 16'h0, 1'b0, 1'b0, "R9 shr 63 zero");
    drive(5'd13, 32'h8000_00F0, 32'd4, 16'h0, 1'b0, 1'b0, "R9 shr 4");
    drive(5'd12, 32'h0000_0001, 32'h0000_0043, 16'h0, 1'b0, 1'b0, "R9 high amount bits ignored");
    // R10
    drive(5'd14, 32'hFFFF_FFF8, 32'd0, 16'd2, 1'b1, 1'b0, "R10 sra no lost ones");
    drive(5'd14, 32'hFFFF_FFF9, 32'd0, 16'd1, 1'b0, 1'b0, "R10 sra lost one");
    drive(5'd14, 32'h0000_0007, 32'd0, 16'd1, 1'b1, 1'b0, "R10 sra positive");
    drive(5'd14, 32'hFFFF_FFFF, 32'd0, 16'd0, 1'b1, 1'b0, "R10 sra by zero");
    // R11
    drive(5'd15, 32'd5, 32'd0, 16'h0, 1'b0, 1'b0, "R11 neg");
    drive(5'd15, 32'h8000_0000, 32'd0, 16'h0, 1'b0, 1'b0, "R11 neg min");
    drive(5'd15, 32'd0, 32'd0, 16'h0, 1'b0, 1'b0, "R11 neg zero");
    // R12
    drive(5'd16, 32'd0, 32'd0, 16'h0, 1'b1, 1'b0, "R12 clz zero");
    drive(5'd16, 32'd1, 32'd0, 16'h0, 1'b0, 1'b0, "R12 clz one");
    drive(5'd16, 32'h8000_0000, 32'd0, 16'h0, 1'b0, 1'b0, "R12 clz msb");
    drive(5'd16, 32'h0001_0000, 32'd0, 16'h0, 1'b0, 1'b0, "R12 clz mid");
    idle_hold_check("R1 hold after clz");

    repeat (3) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d results missing, expected 0", sb_q.size());
    end
    done = 1;
    report();
  end
endmodule